// File: doc/BRIEF.md
# Write-Through Device Cache with Memory-Type Control

This block is a small direct-mapped data cache placed between one requester and a slow device-register memory port. Every request carries an operation (load, store, prefetch, flush) and a memory-type attribute (uncacheable, write-combining, write-through). Only write-through traffic may allocate lines. Uncacheable and write-combining traffic goes straight to the memory port. Lines are never dirty, because every store is written through. A flush therefore only invalidates a line and never writes it back.

The requester sees a valid/ready request channel and a response pulse that carries load data. The memory side is a one-word request/response port whose response latency varies. The block has at most one memory transaction in flight and handles requests strictly in arrival order. A flush followed at once by a prefetch of the same line therefore leaves the freshly fetched line valid. Software keeps the cache coherent with a changing device by flushing a line and then prefetching it again.

Top module: `wtc_cache`

## Requirements
- R1: A write-through load (memory type 2) that misses reads the whole 8-word line from the memory port, one word per transaction, in ascending word order starting at the line base. Once the last word arrives, the block returns the requested word on the response channel.
- R2: Once a line is filled, a write-through load to any word of that line returns the cached word on the cycle after acceptance, with no memory-port transaction.
- R3: A load with memory type 0 (uncacheable), 1 (write-combining) or 3 (treated as uncacheable) makes exactly one memory read at the word address and returns the value read, even when a valid line holds that address. It allocates nothing and leaves the cached copy unchanged.
- R4: Every store (op 1) sends one write with its address and data to the memory port on the cycle after acceptance. If a valid line holds that address, the cached word is updated as well.
- R5: A store that misses does not allocate a line. A later write-through load of that address still refills the line.
- R6: A prefetch (op 2) with a non-write-through memory type is discarded. It causes no memory transaction and no response.
- R7: A write-through prefetch that misses fills the line exactly as in R1 but returns no response. A prefetch that hits does nothing.
- R8: A flush (op 3) invalidates the line that holds the address. It causes no memory transaction and no response, and the next write-through load of that line refills it from memory.
- R9: Requests take effect in arrival order. A prefetch accepted right after a flush of the same line leaves the line valid, holding current memory contents.
- R10: Only one memory transaction is outstanding at any time. `req_ready` stays low from acceptance of a request that needs the memory port until that work completes.
- R11: After reset, `req_ready` is high, `rsp_valid` and `mem_req_valid` are low, and every line is invalid.

Op encoding: 0 load, 1 store, 2 prefetch, 3 flush. Memory types: 0 uncacheable, 1 write-combining, 2 write-through, 3 treated as uncacheable. The address splits into byte offset [1:0], word-in-line [4:2], line index [8:5] and tag [31:9].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_op | input | 2 | Operation: 0 load, 1 store, 2 prefetch, 3 flush |
| req_mtype | input | 2 | Memory type: 0 UC, 1 WC, 2 WT, 3 as UC |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | One-cycle pulse with load data |
| rsp_rdata | output | 32 | Load data |
| mem_req_valid | output | 1 | One-cycle memory transaction request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Word-aligned memory address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Memory completion pulse (read data or write acknowledge) |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
The bench changes the backing memory behind the cache to mimic a device that updates its registers. This separates cached values from fresh ones. A design that let an uncacheable load hit the cache, or that allocated on it, would return stale data. A flush that failed to invalidate would keep serving the old word. A flush issued back-to-back with a prefetch checks ordering: a design that let the prefetch overtake the invalidate would miss on the following load. Memory traffic is counted per operation, which exposes prefetches that are not dropped, stores that allocate, and refills that fetch the wrong words or the wrong number of words.

// File: rtl/wtc_pkg.sv
// Shared encodings for the write-through cache.
package wtc_pkg;
    typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_PREFETCH = 2'd2, OP_FLUSH = 2'd3} wtc_op_e;
    typedef enum logic [1:0] {MT_UC = 2'd0, MT_WC = 2'd1, MT_WT = 2'd2, MT_RSV = 2'd3} wtc_mtype_e;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ISSUE = 2'd1, ST_WAIT = 2'd2} wtc_state_e;
    typedef enum logic [1:0] {TX_READ = 2'd0, TX_WRITE = 2'd1, TX_FILL = 2'd2} wtc_txn_e;
endpackage

// File: rtl/wtc_tag_store.sv
// Tag and valid storage of a direct-mapped cache.
// Assumes set and clear never target the same line in one cycle; clear wins if they do.
module wtc_tag_store #(
    parameter int LINES = 16,
    parameter int IDX_W = 4,
    parameter int TAG_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx
);
    logic             valid_q [LINES];
    logic [TAG_W-1:0] tag_q   [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        // Valid bit per line: cleared by reset or invalidate, set by a completed fill.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  valid_q[i] <= 1'b0;
            else if (clr_en && clr_idx == IDX_W'(i))     valid_q[i] <= 1'b0;
            else if (set_en && set_idx == IDX_W'(i))     valid_q[i] <= 1'b1;
        end
        // Tag per line: written when a fill completes.
        always_ff @(posedge clk) begin
            if (set_en && set_idx == IDX_W'(i)) tag_q[i] <= set_tag;
        end
    end

    // Lookup compare for the presented index.
    always_comb lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
endmodule

// File: rtl/wtc_data_store.sv
// Word-addressed line data. Contents are not reset; valid bits guard them.
module wtc_data_store #(
    parameter int LINES  = 16,
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    parameter int WORD_W = 3
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WORD_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = LINES * WORDS;
    logic [DATA_W-1:0] word_q [DEPTH];

    // Single write port.
    always_ff @(posedge clk) begin
        if (wr_en) word_q[{wr_idx, wr_word}] <= wr_data;
    end

    // Asynchronous read of the addressed word.
    always_comb rd_data = word_q[{rd_idx, rd_word}];
endmodule

// File: rtl/wtc_ctrl.sv
// Request sequencer: decodes op and memory type, serves hits, runs single
// reads, write-through writes and line refills one memory word at a time.
// Assumes the memory answers every request with exactly one mem_rsp_valid pulse.
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 4,
    parameter int WORD_W   = 3,
    parameter int TAG_W    = 23,
    parameter int BYTE_OFF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [1:0]        req_mtype,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] rd_data,
    output logic              tag_set,
    output logic [IDX_W-1:0]  tag_set_idx,
    output logic [TAG_W-1:0]  tag_set_tag,
    output logic              tag_clr,
    output logic [IDX_W-1:0]  tag_clr_idx,
    output logic              dat_we,
    output logic [IDX_W-1:0]  dat_idx,
    output logic [WORD_W-1:0] dat_word,
    output logic [DATA_W-1:0] dat_wdata
);
    localparam int LINE_LSB = BYTE_OFF + WORD_W;
    localparam int WADDR_W  = ADDR_W - BYTE_OFF;

    wtc_state_e         state_q;
    wtc_txn_e           txn_q;
    logic [WADDR_W-1:0] addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic               ret_q;
    logic [WORD_W-1:0]  cnt_q;
    logic [DATA_W-1:0]  hold_q;

    wtc_op_e           op;
    logic              is_wt, accept;
    logic [IDX_W-1:0]  a_idx, q_idx;
    logic [WORD_W-1:0] a_word, q_word;
    logic [TAG_W-1:0]  q_tag;
    logic              hit_load, go_read, go_write, go_fill, flush_hit, store_hit, fill_beat;
    logic              addr_lsb_unused;

    // Request field decode.
    always_comb begin
        op        = wtc_op_e'(req_op);
        is_wt     = (wtc_mtype_e'(req_mtype) == MT_WT);
        req_ready = (state_q == ST_IDLE);
        accept    = req_valid && req_ready;
        a_idx     = req_addr[LINE_LSB +: IDX_W];
        a_word    = req_addr[BYTE_OFF +: WORD_W];
        q_idx     = addr_q[WORD_W +: IDX_W];
        q_word    = addr_q[WORD_W-1:0];
        q_tag     = addr_q[WADDR_W-1 -: TAG_W];
        addr_lsb_unused = ^req_addr[BYTE_OFF-1:0];
    end

    // Per-request decisions taken at acceptance.
    always_comb begin
        hit_load  = accept && op == OP_LOAD && is_wt && lk_hit;
        go_read   = accept && op == OP_LOAD && !is_wt;
        go_write  = accept && op == OP_STORE;
        go_fill   = accept && is_wt && !lk_hit && (op == OP_LOAD || op == OP_PREFETCH);
        flush_hit = accept && op == OP_FLUSH && lk_hit;
        store_hit = accept && op == OP_STORE && lk_hit;
        fill_beat = state_q == ST_WAIT && txn_q == TX_FILL && mem_rsp_valid;
    end

    // Tag-store control: invalidate on flush hit or before a refill, validate after the last beat.
    always_comb begin
        tag_clr     = flush_hit || go_fill;
        tag_clr_idx = a_idx;
        tag_set     = fill_beat && (&cnt_q);
        tag_set_idx = q_idx;
        tag_set_tag = q_tag;
    end

    // Data-store write mux: refill beat or store hit update.
    always_comb begin
        dat_we    = fill_beat || store_hit;
        dat_idx   = fill_beat ? q_idx : a_idx;
        dat_word  = fill_beat ? cnt_q : a_word;
        dat_wdata = fill_beat ? mem_rsp_rdata : req_wdata;
    end

    // Memory port drive from the latched request.
    always_comb begin
        mem_req_valid = (state_q == ST_ISSUE);
        mem_req_we    = (txn_q == TX_WRITE);
        mem_req_wdata = wdata_q;
        if (txn_q == TX_FILL)
            mem_req_addr = {addr_q[WADDR_W-1:WORD_W], cnt_q, {BYTE_OFF{1'b0}}};
        else
            mem_req_addr = {addr_q, {BYTE_OFF{1'b0}}};
    end

    // Sequencer state, latched request and response generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            txn_q     <= TX_READ;
            addr_q    <= '0;
            wdata_q   <= '0;
            ret_q     <= 1'b0;
            cnt_q     <= '0;
            hold_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (hit_load) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= rd_data;
                    end
                    if (go_read || go_write || go_fill) begin
                        state_q <= ST_ISSUE;
                        addr_q  <= req_addr[ADDR_W-1:BYTE_OFF];
                        wdata_q <= req_wdata;
                        ret_q   <= (op == OP_LOAD);
                        cnt_q   <= '0;
                        txn_q   <= go_fill ? TX_FILL : (go_write ? TX_WRITE : TX_READ);
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        case (txn_q)
                            TX_READ: begin
                                rsp_valid <= 1'b1;
                                rsp_rdata <= mem_rsp_rdata;
                                state_q   <= ST_IDLE;
                            end
                            TX_FILL: begin
                                if (cnt_q == q_word) hold_q <= mem_rsp_rdata;
                                if (&cnt_q) begin
                                    state_q   <= ST_IDLE;
                                    rsp_valid <= ret_q;
                                    rsp_rdata <= (cnt_q == q_word) ? mem_rsp_rdata : hold_q;
                                end else begin
                                    cnt_q   <= cnt_q + 1'b1;
                                    state_q <= ST_ISSUE;
                                end
                            end
                            default: state_q <= ST_IDLE;
                        endcase
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wtc_cache.sv
// Top of the write-through device cache: direct-mapped, no write-allocate,
// invalidate-only flush, one memory transaction in flight, in-order requests.
module wtc_cache #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINES      = 16,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [1:0]        req_mtype,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata
);
    localparam int BYTE_OFF = $clog2(DATA_W / 8);
    localparam int WORDS    = LINE_BYTES / (DATA_W / 8);
    localparam int WORD_W   = $clog2(WORDS);
    localparam int IDX_W    = $clog2(LINES);
    localparam int TAG_W    = ADDR_W - IDX_W - WORD_W - BYTE_OFF;
    localparam int LINE_LSB = BYTE_OFF + WORD_W;

    logic              lk_hit;
    logic [DATA_W-1:0] rd_data;
    logic              tag_set, tag_clr, dat_we;
    logic [IDX_W-1:0]  tag_set_idx, tag_clr_idx, dat_idx;
    logic [TAG_W-1:0]  tag_set_tag;
    logic [WORD_W-1:0] dat_word;
    logic [DATA_W-1:0] dat_wdata;

    wtc_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(req_addr[LINE_LSB +: IDX_W]), .lk_tag(req_addr[ADDR_W-1 -: TAG_W]), .lk_hit(lk_hit),
        .set_en(tag_set), .set_idx(tag_set_idx), .set_tag(tag_set_tag),
        .clr_en(tag_clr), .clr_idx(tag_clr_idx)
    );

    wtc_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W), .WORD_W(WORD_W)) u_data (
        .clk(clk),
        .rd_idx(req_addr[LINE_LSB +: IDX_W]), .rd_word(req_addr[BYTE_OFF +: WORD_W]), .rd_data(rd_data),
        .wr_en(dat_we), .wr_idx(dat_idx), .wr_word(dat_word), .wr_data(dat_wdata)
    );

    wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .WORD_W(WORD_W),
               .TAG_W(TAG_W), .BYTE_OFF(BYTE_OFF)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_mtype(req_mtype),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .lk_hit(lk_hit), .rd_data(rd_data),
        .tag_set(tag_set), .tag_set_idx(tag_set_idx), .tag_set_tag(tag_set_tag),
        .tag_clr(tag_clr), .tag_clr_idx(tag_clr_idx),
        .dat_we(dat_we), .dat_idx(dat_idx), .dat_word(dat_word), .dat_wdata(dat_wdata)
    );
endmodule

// File: rtl/wtc_cache_chk.sv
// Port-level protocol checker for wtc_cache, attached by bind.
module wtc_cache_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_op,
    input logic [1:0]        req_mtype,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_we,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [DATA_W-1:0] mem_req_wdata,
    input logic              mem_rsp_valid
);
    localparam int BO = $clog2(DATA_W / 8);

    logic acc, outst_q;
    always_comb acc = req_valid && req_ready;

    // Tracks whether a memory transaction is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)             outst_q <= 1'b0;
        else if (mem_req_valid) outst_q <= 1'b1;
        else if (mem_rsp_valid) outst_q <= 1'b0;
    end

    p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !outst_q);
    p_ready_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q |-> !req_ready);
    p_store_thru_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op == 2'd1) |=> (mem_req_valid && mem_req_we
            && mem_req_addr[ADDR_W-1:BO] == $past(req_addr[ADDR_W-1:BO])
            && mem_req_wdata == $past(req_wdata)));
    p_bypass_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op == 2'd0 && req_mtype != 2'd2) |=> (mem_req_valid && !mem_req_we
            && mem_req_addr[ADDR_W-1:BO] == $past(req_addr[ADDR_W-1:BO])));
    p_drop_prefetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op == 2'd2 && req_mtype != 2'd2) |=> (!mem_req_valid && !rsp_valid));
    p_prefetch_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op == 2'd2) |=> !rsp_valid);
    p_flush_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op == 2'd3) |=> (!mem_req_valid && !rsp_valid));
endmodule

bind wtc_cache wtc_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_mtype(req_mtype), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/wtc_cache_bench.sv
module wtc_cache_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [1:0]  req_mtype = 2'd0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_req_valid, mem_req_we;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wtc_cache u_wtc_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_mtype(req_mtype), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int viol = 0;
    logic [31:0] rd_log[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] bk_mem[logic [31:0]];

    // Backing device memory: default pattern plus overrides.
    function automatic logic [31:0] mrd(logic [31:0] a);
        if (bk_mem.exists(a)) return bk_mem[a];
        return {~a[15:0], a[15:0]};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Memory model with variable latency; also watches the one-outstanding rule (R10).
    initial begin
        bit          outst = 0;
        int          wait_n = 0;
        int          nreq = 0;
        logic [31:0] pend_data = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (outst) begin
                if (wait_n == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = pend_data;
                    outst = 0;
                end else wait_n--;
            end
            if (rst_n && mem_req_valid) begin
                if (outst) viol++;
                if (mem_req_we) begin
                    wr_cnt++;
                    bk_mem[mem_req_addr] = mem_req_wdata;
                    pend_data = '0;
                end else begin
                    rd_cnt++;
                    rd_log.push_back(mem_req_addr);
                    pend_data = mrd(mem_req_addr);
                end
                outst = 1;
                wait_n = nreq % 4;
                nreq++;
            end
            if (rst_n && outst && req_ready) viol++;
        end
    end

    // Scoreboard monitor: every response must match the oldest expected load.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (exp_q.size() == 0) check(0, "R6 R7 unexpected response", rsp_rdata, '0);
                else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(rsp_rdata === e, t, rsp_rdata, e);
                end
            end
        end
    end

    // Driver: present one request, hold until accepted; loads push their expectation.
    task automatic drive(logic [1:0] op, logic [1:0] mt, logic [31:0] a, logic [31:0] wd,
                         logic [31:0] exp, string t);
        if (op == 2'd0) begin
            exp_q.push_back(exp);
            tag_q.push_back(t);
        end
        req_op = op; req_mtype = mt; req_addr = a; req_wdata = wd; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        while (!req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run(logic [1:0] op, logic [1:0] mt, logic [31:0] a, logic [31:0] wd,
                       logic [31:0] exp, string t);
        drive(op, mt, a, wd, exp, t);
        settle();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R10 watchdog expired act=%h exp=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        int r0, w0;
        logic [31:0] old_v;
        repeat (3) @(negedge clk);
        // R11: reset values
        check(req_ready === 1'b1, "R11 ready in reset", {31'd0, req_ready}, 32'd1);
        check(rsp_valid === 1'b0 && mem_req_valid === 1'b0, "R11 outputs idle",
              {30'd0, rsp_valid, mem_req_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: load miss refills the whole line in ascending order
        rd_log.delete(); r0 = rd_cnt;
        run(2'd0, 2'd2, 32'h0000_1104, '0, mrd(32'h0000_1104), "R1 miss data");
        check(rd_cnt - r0 == 8, "R1 refill length", rd_cnt - r0, 8);
        for (int k = 0; k < 8; k++)
            check(rd_log[k] == 32'h0000_1100 + 4 * k, "R1 refill order", rd_log[k], 32'h0000_1100 + 4 * k);

        // R2: hit served with no traffic
        r0 = rd_cnt;
        run(2'd0, 2'd2, 32'h0000_111C, '0, mrd(32'h0000_111C), "R2 hit data");
        check(rd_cnt == r0, "R2 no memory read on hit", rd_cnt - r0, 0);

        // R3: device updates a word; UC and WC loads see it, cached copy stays
        old_v = mrd(32'h0000_1108);
        bk_mem[32'h0000_1108] = 32'hCAFE_0001;
        bk_mem[32'h0000_110C] = 32'hCAFE_0002;
        r0 = rd_cnt;
        run(2'd0, 2'd0, 32'h0000_1108, '0, 32'hCAFE_0001, "R3 UC bypass data");
        run(2'd0, 2'd1, 32'h0000_110C, '0, 32'hCAFE_0002, "R3 WC bypass data");
        check(rd_cnt - r0 == 2, "R3 one read per bypass load", rd_cnt - r0, 2);
        r0 = rd_cnt;
        run(2'd0, 2'd2, 32'h0000_1108, '0, old_v, "R3 cached copy unchanged");
        check(rd_cnt == r0, "R3 line still valid", rd_cnt - r0, 0);

        // R4: store hit writes through and updates the line
        w0 = wr_cnt;
        run(2'd1, 2'd2, 32'h0000_1110, 32'h1234_5678, '0, "");
        check(wr_cnt - w0 == 1, "R4 one write", wr_cnt - w0, 1);
        check(mrd(32'h0000_1110) == 32'h1234_5678, "R4 memory updated", mrd(32'h0000_1110), 32'h1234_5678);
        r0 = rd_cnt;
        run(2'd0, 2'd2, 32'h0000_1110, '0, 32'h1234_5678, "R4 cached word updated");
        check(rd_cnt == r0, "R4 hit after store", rd_cnt - r0, 0);

        // R5: store miss does not allocate
        w0 = wr_cnt;
        run(2'd1, 2'd2, 32'h0000_2200, 32'hAAAA_5555, '0, "");
        check(wr_cnt - w0 == 1, "R5 write through on miss", wr_cnt - w0, 1);
        r0 = rd_cnt;
        run(2'd0, 2'd2, 32'h0000_2200, '0, 32'hAAAA_5555, "R5 load after store miss");
        check(rd_cnt - r0 == 8, "R5 no allocation", rd_cnt - r0, 8);

        // R6: non-WT prefetch discarded
        r0 = rd_cnt; w0 = wr_cnt;
        run(2'd2, 2'd0, 32'h0000_3300, '0, '0, "");
        run(2'd2, 2'd1, 32'h0000_3304, '0, '0, "");
        check(rd_cnt == r0 && wr_cnt == w0, "R6 no traffic", rd_cnt - r0 + wr_cnt - w0, 0);
        r0 = rd_cnt;
        run(2'd0, 2'd2, 32'h0000_3300, '0, mrd(32'h0000_3300), "R6 line not filled");
        check(rd_cnt - r0 == 8, "R6 later load misses", rd_cnt - r0, 8);

        // R7: WT prefetch fills silently; prefetch hit is a no-op
        r0 = rd_cnt;
        run(2'd2, 2'd2, 32'h0000_4400, '0, '0, "");
        check(rd_cnt - r0 == 8, "R7 prefetch fill", rd_cnt - r0, 8);
        r0 = rd_cnt;
        run(2'd2, 2'd2, 32'h0000_4400, '0, '0, "");
        run(2'd0, 2'd2, 32'h0000_4404, '0, mrd(32'h0000_4404), "R7 prefetched data");
        check(rd_cnt == r0, "R7 no traffic after prefetch", rd_cnt - r0, 0);

        // R8: flush invalidates without writeback
        old_v = mrd(32'h0000_4408);
        bk_mem[32'h0000_4408] = 32'hBEEF_0008;
        run(2'd0, 2'd2, 32'h0000_4408, '0, old_v, "R8 stale before flush");
        r0 = rd_cnt; w0 = wr_cnt;
        run(2'd3, 2'd2, 32'h0000_4400, '0, '0, "");
        check(rd_cnt == r0 && wr_cnt == w0, "R8 flush no traffic", rd_cnt - r0 + wr_cnt - w0, 0);
        run(2'd0, 2'd2, 32'h0000_4408, '0, 32'hBEEF_0008, "R8 fresh after flush");
        check(rd_cnt - r0 == 8, "R8 refill after flush", rd_cnt - r0, 8);

        // R9: back-to-back flush then prefetch keeps order
        bk_mem[32'h0000_4410] = 32'hD00D_0010;
        r0 = rd_cnt;
        drive(2'd3, 2'd2, 32'h0000_4400, '0, '0, "");
        drive(2'd2, 2'd2, 32'h0000_4400, '0, '0, "");
        settle();
        check(rd_cnt - r0 == 8, "R9 prefetch refilled", rd_cnt - r0, 8);
        r0 = rd_cnt;
        run(2'd0, 2'd2, 32'h0000_4410, '0, 32'hD00D_0010, "R9 fresh data");
        check(rd_cnt == r0, "R9 line valid after flush+prefetch", rd_cnt - r0, 0);

        // R10: back-to-back memory ops with no overlap or early ready
        drive(2'd0, 2'd0, 32'h0000_5500, '0, mrd(32'h0000_5500), "R10 UC load");
        drive(2'd1, 2'd0, 32'h0000_5504, 32'h0F0F_0F0F, '0, "");
        drive(2'd0, 2'd2, 32'h0000_5504, '0, 32'h0F0F_0F0F, "R10 refill after store");
        settle();
        check(viol == 0, "R10 single outstanding, ready low", viol, 0);
        check(exp_q.size() == 0, "R1 R2 all responses seen", exp_q.size(), 0);
        finish_run();
    end
endmodule